// File: doc/BRIEF.md
# Zero-Address Stack Instruction Executor

This block is a small sequential processor core. Its arithmetic instructions name no operand. They take their inputs from an internal hardware operand stack and return the result to it. Only the two memory transfer instructions name a location. A push copies a data-memory word onto the stack. A pop writes the top entry to data memory and removes it. An arithmetic instruction removes the two topmost entries, combines them with the top entry as the left-hand operand, and pushes the single result.

Before a run, the surrounding logic fills program memory and data memory through two valid/ready write streams. A write is accepted in a cycle where valid and ready are both high. Ready is high whenever the core is not executing, and it drops for the whole of a run. A producer that holds valid high while ready is low sees nothing happen, and it must keep its word until ready returns. A one-cycle `start` pulse begins execution at program address 0. The core then retires one instruction per clock until it meets a halt instruction or a stack error. A combinational peek port reads any data-memory word at any time.

Top module: `zstack_core`

## Requirements
- R1: An instruction is 16 bits. Bits [15:12] hold the opcode and bits [11:0] hold the address field. Data memory is addressed by the low DATA_AW bits of the field. The opcodes are PUSH=1, POP=2, ADD=3, SUB=4, MUL=5, DIV=6 and HALT=15. Any other opcode, for example 7, only advances the program counter.
- R2: PUSH places the data-memory word at its address on top of the stack.
- R3: POP writes the top-of-stack value to data memory at its address and removes it from the stack.
- R4: ADD, SUB, MUL and DIV remove the top entry T and the entry N beneath it, and push T op N. SUB gives T-N modulo 2^16, DIV gives T/N rounded toward zero, and MUL keeps the low 16 bits of the product.
- R5: The address field of an arithmetic instruction has no effect on its result.
- R6: DIV with N equal to zero pushes 16'hFFFF and sets `fault`. Execution then continues with the next instruction.
- R7: A PUSH onto a stack that already holds STACK_DEPTH (default 8) entries sets `fault` and stops the core. It does not change the stack or memory, and no later instruction runs.
- R8: A POP on an empty stack, or an arithmetic instruction with fewer than two entries, sets `fault` and stops the core without writing data memory.
- R9: A `start` pulse while the core is not running and `fault` is low restarts at address 0 with an empty stack. Instructions then retire one per clock, so a program of n instructions ending in HALT raises `halted` n cycles after the start edge. `halted` then stays high.
- R10: `fault` is sticky until reset. While `fault` is high, `start` is ignored.
- R11: `prog_ready` and `dmem_ready` are high exactly when the core is not running. A word is written on valid and ready. A word offered while ready is low is not written.
- R12: After a synchronous reset, `halted` and `fault` are low, both readies are high and the stack is empty. Memory contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin execution at program address 0 |
| prog_valid | input | 1 | Program write offered |
| prog_ready | output | 1 | Program write accepted this cycle |
| prog_addr | input | PROG_AW | Program word address |
| prog_data | input | 16 | Instruction word |
| dmem_valid | input | 1 | Data preload write offered |
| dmem_ready | output | 1 | Data preload accepted this cycle |
| dmem_addr | input | DATA_AW | Data preload address |
| dmem_data | input | DATA_W | Data preload word |
| peek_addr | input | DATA_AW | Data memory peek address |
| peek_data | output | DATA_W | Data memory word at peek_addr |
| halted | output | 1 | Core has stopped |
| fault | output | 1 | Sticky stack or divide error |

## Verification
The stack itself cannot be seen at the ports. A wrong stack pointer or a corrupted entry therefore first shows up through a POP: the peek port reads a wrong word in the cycle after that POP retires. A wrong pointer can also raise `fault` and `halted` one cycle after a PUSH or arithmetic instruction that should have succeeded, or fail to raise them. A wrong program counter or state shows at once in the `halted` timing and in the readies. The bench model is therefore compared every cycle on `halted`, `fault`, both readies and a peeked memory word. Programs end with POPs so that every stack value reaches a port.

// File: rtl/zstack_pkg.sv
package zstack_pkg;
  localparam int INSN_W  = 16;
  localparam int OPC_W   = 4;
  localparam int FIELD_W = 12;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP  = 4'd0,
    OP_PUSH = 4'd1,
    OP_POP  = 4'd2,
    OP_ADD  = 4'd3,
    OP_SUB  = 4'd4,
    OP_MUL  = 4'd5,
    OP_DIV  = 4'd6,
    OP_HALT = 4'd15
  } opcode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_STOP
  } core_state_e;

  typedef enum logic [2:0] {
    SK_NONE,
    SK_PUSH,
    SK_POP,
    SK_FOLD,
    SK_CLEAR
  } stk_op_e;
endpackage

// File: rtl/zstack_ram.sv
module zstack_ram #(
  parameter int AW  = 6,
  parameter int W   = 16,
  parameter int NRD = 1
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [W-1:0]            wdata,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][W-1:0]   rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = mem[raddr[g]];
  end
endmodule

// File: rtl/zstack_opstack.sv
module zstack_opstack
  import zstack_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int W     = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  stk_op_e                       op,
  input  logic [W-1:0]                  push_data,
  input  logic [W-1:0]                  fold_data,
  output logic [W-1:0]                  tos,
  output logic [W-1:0]                  nos,
  output logic [$clog2(DEPTH+1)-1:0]    count
);
  localparam int SP_W = $clog2(DEPTH + 1);

  logic [W-1:0] ent [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (op == SK_PUSH && int'(count) == i)
        ent[i] <= push_data;
      else if (op == SK_FOLD && int'(count) == i + 2)
        ent[i] <= fold_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else begin
      case (op)
        SK_PUSH:  count <= count + SP_W'(1);
        SK_POP,
        SK_FOLD:  count <= count - SP_W'(1);
        SK_CLEAR: count <= '0;
        default:  count <= count;
      endcase
    end
  end

  always_comb begin
    tos = '0;
    nos = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (int'(count) == i + 1) tos = ent[i];
      if (int'(count) == i + 2) nos = ent[i];
    end
  end

  AST_STACK_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(count) <= DEPTH);  // R7

  AST_NO_FULL_PUSH: assert property (@(posedge clk) disable iff (rst)
    (op == SK_PUSH) |-> (int'(count) < DEPTH));  // R7

  AST_NO_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    (op == SK_POP) |-> (count != '0));  // R8

  AST_FOLD_NEEDS_TWO: assert property (@(posedge clk) disable iff (rst)
    (op == SK_FOLD) |-> (int'(count) >= 2));  // R8

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (op == SK_FOLD) |=> (count == $past(count) - SP_W'(1)));  // R4
endmodule

// File: rtl/zstack_alu.sv
module zstack_alu
  import zstack_pkg::*;
#(
  parameter int W = 16
) (
  input  opcode_e       opc,
  input  logic [W-1:0]  top,
  input  logic [W-1:0]  below,
  output logic [W-1:0]  result,
  output logic          div_zero
);
  always_comb begin
    div_zero = 1'b0;
    case (opc)
      OP_SUB:  result = top - below;
      OP_MUL:  result = top * below;
      OP_DIV: begin
        if (below == '0) begin
          result   = '1;
          div_zero = 1'b1;
        end else begin
          result = top / below;
        end
      end
      default: result = top + below;
    endcase
  end
endmodule

// File: rtl/zstack_core.sv
module zstack_core
  import zstack_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int STACK_DEPTH = 8,
  parameter int PROG_AW     = 6,
  parameter int DATA_AW     = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                prog_valid,
  output logic                prog_ready,
  input  logic [PROG_AW-1:0]  prog_addr,
  input  logic [INSN_W-1:0]   prog_data,
  input  logic                dmem_valid,
  output logic                dmem_ready,
  input  logic [DATA_AW-1:0]  dmem_addr,
  input  logic [DATA_W-1:0]   dmem_data,
  input  logic [DATA_AW-1:0]  peek_addr,
  output logic [DATA_W-1:0]   peek_data,
  output logic                halted,
  output logic                fault
);
  localparam int SP_W = $clog2(STACK_DEPTH + 1);

  core_state_e          state;
  logic [PROG_AW-1:0]   pc;
  logic [INSN_W-1:0]    insn;
  opcode_e              opc;
  logic [FIELD_W-1:0]   field;
  logic [DATA_AW-1:0]   op_addr;

  stk_op_e              stk_op;
  logic [DATA_W-1:0]    tos, nos, alu_res;
  logic [SP_W-1:0]      depth;
  logic                 div_zero;

  logic                 pc_adv, go_stop, stk_err, raise;
  logic                 core_we;
  logic                 launch;

  logic                 dm_we;
  logic [DATA_AW-1:0]   dm_waddr;
  logic [DATA_W-1:0]    dm_wdata;
  logic [1:0][DATA_AW-1:0] dm_raddr;
  logic [1:0][DATA_W-1:0]  dm_rdata;
  logic [0:0][PROG_AW-1:0] pm_raddr;
  logic [0:0][INSN_W-1:0]  pm_rdata;

  // Program store
  assign pm_raddr[0] = pc;
  zstack_ram #(.AW(PROG_AW), .W(INSN_W), .NRD(1)) prog_mem_i (
    .clk   (clk),
    .we    (prog_valid && prog_ready),
    .waddr (prog_addr),
    .wdata (prog_data),
    .raddr (pm_raddr),
    .rdata (pm_rdata)
  );

  assign insn    = pm_rdata[0];
  assign opc     = opcode_e'(insn[INSN_W-1 -: OPC_W]);
  assign field   = insn[FIELD_W-1:0];
  assign op_addr = field[DATA_AW-1:0];

  // Data store: port 0 feeds PUSH, port 1 feeds the peek output
  assign dm_raddr[0] = op_addr;
  assign dm_raddr[1] = peek_addr;
  assign dm_we    = core_we || (dmem_valid && dmem_ready);
  assign dm_waddr = core_we ? op_addr : dmem_addr;
  assign dm_wdata = core_we ? tos     : dmem_data;

  zstack_ram #(.AW(DATA_AW), .W(DATA_W), .NRD(2)) data_mem_i (
    .clk   (clk),
    .we    (dm_we),
    .waddr (dm_waddr),
    .wdata (dm_wdata),
    .raddr (dm_raddr),
    .rdata (dm_rdata)
  );
  assign peek_data = dm_rdata[1];

  zstack_opstack #(.DEPTH(STACK_DEPTH), .W(DATA_W)) opstack_i (
    .clk       (clk),
    .rst       (rst),
    .op        (stk_op),
    .push_data (dm_rdata[0]),
    .fold_data (alu_res),
    .tos       (tos),
    .nos       (nos),
    .count     (depth)
  );

  zstack_alu #(.W(DATA_W)) alu_i (
    .opc      (opc),
    .top      (tos),
    .below    (nos),
    .result   (alu_res),
    .div_zero (div_zero)
  );

  assign launch = start && !fault && (state != ST_RUN);

  // Decode and sequencing
  always_comb begin
    stk_op  = launch ? SK_CLEAR : SK_NONE;
    core_we = 1'b0;
    pc_adv  = 1'b0;
    go_stop = 1'b0;
    stk_err = 1'b0;
    raise   = 1'b0;
    if (state == ST_RUN) begin
      case (opc)
        OP_PUSH: begin
          if (int'(depth) == STACK_DEPTH) stk_err = 1'b1;
          else begin
            stk_op = SK_PUSH;
            pc_adv = 1'b1;
          end
        end
        OP_POP: begin
          if (depth == '0) stk_err = 1'b1;
          else begin
            stk_op  = SK_POP;
            core_we = 1'b1;
            pc_adv  = 1'b1;
          end
        end
        OP_ADD, OP_SUB, OP_MUL, OP_DIV: begin
          if (int'(depth) < 2) stk_err = 1'b1;
          else begin
            stk_op = SK_FOLD;
            pc_adv = 1'b1;
            raise  = div_zero;
          end
        end
        OP_HALT: go_stop = 1'b1;
        default: pc_adv  = 1'b1;
      endcase
      if (stk_err) begin
        raise   = 1'b1;
        go_stop = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      pc    <= '0;
      fault <= 1'b0;
    end else begin
      if (raise) fault <= 1'b1;
      if (launch) begin
        state <= ST_RUN;
        pc    <= '0;
      end else if (go_stop) begin
        state <= ST_STOP;
      end else if (pc_adv) begin
        pc <= pc + PROG_AW'(1);
      end
    end
  end

  assign halted     = (state == ST_STOP);
  assign prog_ready = (state != ST_RUN);
  assign dmem_ready = (state != ST_RUN);

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(fault)) |-> fault);  // R10

  AST_STACKERR_HALTS: assert property (@(posedge clk) disable iff (rst)
    stk_err |=> (halted && fault));  // R7

  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (halted && !start) |=> (halted && $stable(pc)));  // R9

  AST_NO_LOAD_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && !core_we) |=> $stable(peek_data) || $changed(peek_addr));  // R11

  AST_FAULT_BLOCKS_START: assert property (@(posedge clk) disable iff (rst)
    (fault && state != ST_RUN) |=> (state != ST_RUN));  // R10
endmodule

// File: tb/zstack_core_tb.sv
module zstack_core_tb_top;
  localparam int PAW = 6;
  localparam int DAW = 6;
  localparam int NP  = 1 << PAW;
  localparam int ND  = 1 << DAW;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic           prog_valid = 1'b0;
  logic           prog_ready;
  logic [PAW-1:0] prog_addr = '0;
  logic [15:0]    prog_data = '0;
  logic           dmem_valid = 1'b0;
  logic           dmem_ready;
  logic [DAW-1:0] dmem_addr = '0;
  logic [15:0]    dmem_data = '0;
  logic [DAW-1:0] peek_addr = '0;
  logic [15:0]    peek_data;
  logic           halted, fault;

  zstack_core #(.DATA_W(16), .STACK_DEPTH(8), .PROG_AW(PAW), .DATA_AW(DAW)) dut_i (
    .clk(clk), .rst(rst), .start(start),
    .prog_valid(prog_valid), .prog_ready(prog_ready),
    .prog_addr(prog_addr), .prog_data(prog_data),
    .dmem_valid(dmem_valid), .dmem_ready(dmem_ready),
    .dmem_addr(dmem_addr), .dmem_data(dmem_data),
    .peek_addr(peek_addr), .peek_data(peek_data),
    .halted(halted), .fault(fault)
  );

  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_pm [NP];
  logic [15:0] m_dm [ND];
  logic [15:0] m_stk [$];
  int          m_state = 0;   // 0 idle, 1 running, 2 stopped
  int          m_pc = 0;
  bit          m_fault = 0;
  bit          model_on = 0;

  task automatic m_step();
    int op, a;
    logic [15:0] t, n, r;
    op = int'(m_pm[m_pc][15:12]);
    a  = int'(m_pm[m_pc][DAW-1:0]);
    case (op)
      1: if (m_stk.size() == 8) begin m_fault = 1; m_state = 2; end
         else begin m_stk.push_back(m_dm[a]); m_pc = (m_pc + 1) % NP; end
      2: if (m_stk.size() == 0) begin m_fault = 1; m_state = 2; end
         else begin m_dm[a] = m_stk.pop_back(); m_pc = (m_pc + 1) % NP; end
      3, 4, 5, 6: begin
        if (m_stk.size() < 2) begin m_fault = 1; m_state = 2; end
        else begin
          t = m_stk.pop_back();
          n = m_stk.pop_back();
          case (op)
            3: r = t + n;
            4: r = t - n;
            5: r = 16'((32'(t) * 32'(n)) % 65536);
            default: if (n == 0) begin r = 16'hFFFF; m_fault = 1; end
                     else r = t / n;
          endcase
          m_stk.push_back(r);
          m_pc = (m_pc + 1) % NP;
        end
      end
      15: m_state = 2;
      default: m_pc = (m_pc + 1) % NP;
    endcase
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_state = 0; m_pc = 0; m_fault = 0; m_stk.delete();
    end else if (m_state == 1) begin
      m_step();
    end else begin
      if (prog_valid) m_pm[prog_addr] = prog_data;
      if (dmem_valid) m_dm[dmem_addr] = dmem_data;
      if (start && !m_fault) begin
        m_state = 1; m_pc = 0; m_stk.delete();
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (model_on && !rst) begin
      chk(halted == (m_state == 2), "R9", "model halted", int'(halted), int'(m_state == 2));
      chk(fault == m_fault, "R10", "model fault", int'(fault), int'(m_fault));
      chk(dmem_ready == (m_state != 1), "R11", "model dmem_ready", int'(dmem_ready), int'(m_state != 1));
      chk(prog_ready == (m_state != 1), "R11", "model prog_ready", int'(prog_ready), int'(m_state != 1));
      chk(peek_data == m_dm[peek_addr], "R3", "model peek", int'(peek_data), int'(m_dm[peek_addr]));
    end
  end

  // watchdog
  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [15:0] ins(input int op, input int a);
    return {4'(op), 12'(a)};
  endfunction

  function automatic logic [15:0] init_val(input int i);
    case (i)
      1: return 16'd3;   2: return 16'd4;   3: return 16'd5;
      4: return 16'd6;   5: return 16'd300; 6: return 16'd0;
      7: return 16'd20;  8: return 16'd10;  9: return 16'd4;
      default: return 16'(i + 100);
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic load_prog(input logic [15:0] w[$]);
    for (int i = 0; i < NP; i++) begin
      @(negedge clk);
      prog_valid = 1'b1;
      prog_addr  = PAW'(i);
      prog_data  = (i < w.size()) ? w[i] : ins(15, 0);
    end
    @(negedge clk); prog_valid = 1'b0;
  endtask

  task automatic load_data();
    for (int i = 0; i < ND; i++) begin
      @(negedge clk);
      dmem_valid = 1'b1;
      dmem_addr  = DAW'(i);
      dmem_data  = init_val(i);
    end
    @(negedge clk); dmem_valid = 1'b0;
  endtask

  task automatic peek(input int a, output int v);
    peek_addr = DAW'(a);
    #1;
    v = int'(peek_data);
  endtask

  // pulse start, then count cycles until halted
  task automatic run(input string tag, input int exp_steps, input bit inject);
    int n = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (inject) begin
      dmem_valid = 1'b1; dmem_addr = DAW'(20); dmem_data = 16'hDEAD;
      #1;
      chk(prog_ready == 1'b0, "R11", "prog_ready while running", int'(prog_ready), 0);
      chk(dmem_ready == 1'b0, "R11", "dmem_ready while running", int'(dmem_ready), 0);
    end
    while (!halted && n < 300) begin
      @(negedge clk);
      n++;
      if (n == 2) dmem_valid = 1'b0;
    end
    dmem_valid = 1'b0;
    chk(n == exp_steps, tag, "cycles to halted", n, exp_steps);
  endtask

  initial begin
    logic [15:0] p[$];
    int v;

    do_reset();
    #2;
    chk(halted == 1'b0, "R12", "halted after reset", int'(halted), 0);
    chk(fault == 1'b0, "R12", "fault after reset", int'(fault), 0);
    chk(prog_ready && dmem_ready, "R12", "readies after reset", int'(prog_ready && dmem_ready), 1);

    load_data();
    load_prog('{});
    model_on = 1;

    // (A+B)*(C+D) with a nonzero field on the first ADD, ignored writes during run
    p = '{ins(1,1), ins(1,2), ins(3,12'hABC), ins(1,3), ins(1,4), ins(3,0),
          ins(5,0), ins(2,10), ins(15,0)};
    load_prog(p);
    run("R9", 9, 1);
    peek(10, v); chk(v == 77, "R2", "expression result M[10]", v, 77);
    chk(v == 77, "R5", "field on ADD ignored", v, 77);
    peek(20, v); chk(v == 120, "R11", "write while not ready dropped", v, 120);
    chk(fault == 1'b0, "R9", "no fault on clean run", int'(fault), 0);

    // restart after HALT reruns from address 0
    run("R9", 9, 0);
    peek(10, v); chk(v == 77, "R9", "rerun result M[10]", v, 77);

    // operand order, MUL truncation, unknown opcode, field on SUB
    p = '{ins(7,12'h123), ins(1,8), ins(1,9), ins(4,12'hFFF), ins(2,11),
          ins(1,9), ins(1,7), ins(6,0), ins(2,12),
          ins(1,5), ins(1,5), ins(5,0), ins(2,13), ins(15,0)};
    load_prog(p);
    run("R1", 14, 0);
    peek(11, v); chk(v == 16'hFFFA, "R4", "SUB top minus below", v, 16'hFFFA);
    peek(12, v); chk(v == 5, "R4", "DIV top over below", v, 5);
    peek(13, v); chk(v == 24464, "R4", "MUL low 16 bits", v, 24464);
    chk(fault == 1'b0, "R1", "unknown opcode is a no-op", int'(fault), 0);

    // divide by zero continues
    p = '{ins(1,6), ins(1,1), ins(6,0), ins(2,14), ins(15,0)};
    load_prog(p);
    run("R6", 5, 0);
    peek(14, v); chk(v == 16'hFFFF, "R6", "div by zero result", v, 16'hFFFF);
    chk(fault == 1'b1, "R6", "div by zero fault", int'(fault), 1);

    // start ignored while fault
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(halted == 1'b1, "R10", "start ignored under fault", int'(halted), 1);
    chk(fault == 1'b1, "R10", "fault sticky", int'(fault), 1);

    // overflow
    do_reset();
    #1;
    chk(fault == 1'b0, "R12", "reset clears fault", int'(fault), 0);
    p = '{};
    for (int i = 0; i < 9; i++) p.push_back(ins(1,1));
    p.push_back(ins(2,15));
    p.push_back(ins(15,0));
    load_prog(p);
    run("R7", 9, 0);
    chk(fault == 1'b1, "R7", "overflow fault", int'(fault), 1);
    peek(15, v); chk(v == 115, "R7", "no pop after overflow", v, 115);

    // underflow on arithmetic
    do_reset();
    p = '{ins(1,1), ins(3,0), ins(2,16), ins(15,0)};
    load_prog(p);
    run("R8", 2, 0);
    chk(fault == 1'b1, "R8", "ADD underflow fault", int'(fault), 1);
    peek(16, v); chk(v == 116, "R8", "no write after ADD underflow", v, 116);

    // underflow on POP
    do_reset();
    p = '{ins(2,17), ins(15,0)};
    load_prog(p);
    run("R8", 1, 0);
    chk(fault == 1'b1, "R8", "POP underflow fault", int'(fault), 1);
    peek(17, v); chk(v == 117, "R8", "empty POP writes nothing", v, 117);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule